// File: doc/BRIEF.md
# Sequential Instruction Loop Buffer

This block sits in an instruction fetch stage and keeps the last 256 bytes that were fetched one after another. Every fetched byte is written in with its address. When a branch target is known, the fetch logic presents the target address with a request strobe. One cycle later the buffer reports whether that byte is held, and returns it if so. A backward branch that closes a short loop can then be served without going to memory. The same applies to a short forward branch that lands in bytes already prefetched past the branch.

The low 8 address bits pick a byte slot. The upper bits are compared against the tag of the window. Because the window slides, it can straddle a 256-byte boundary. Slots at or below the newest slot index therefore belong to the newest tag, and slots above it belong to the tag one lower. Each slot also carries a valid bit. Two events clear every valid bit: a fill that does not follow on from the previous fill address, which also restarts the window, and a synchronous flush.

Top module: `loop_buffer`

## Requirements
- R1: After reset, hit_o and data_o are 0 and no address hits until bytes have been filled.
- R2: A lookup is answered on hit_o/data_o in the cycle after lookup_req_i is sampled high. With lookup_req_i low, hit_o and data_o are 0 in the next cycle.
- R3: A lookup hits and returns the stored byte for any address among the most recent 256 sequential fills. This includes targets ahead of an older branch address inside that range.
- R4: On a miss, data_o is 0. An address that was never filled misses.
- R5: Only address bits [7:0] select the slot. An address with the same low 8 bits as a held byte but different upper bits misses.
- R6: The window slides. After more than 256 sequential fills the oldest addresses miss, and addresses on both sides of a crossed 256-byte boundary hit.
- R7: A fill whose address is not the previous fill address plus one invalidates all earlier bytes and starts a new window at that address.
- R8: flush_i clears every byte in one cycle. A lookup in the same cycle misses. A fill in the same cycle is discarded, and the next fill starts a new window.
- R9: A lookup in the same cycle as the fill of that address misses, because it sees the state before the write. The same lookup one cycle later hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Clear all buffered bytes |
| fill_valid_i | input | 1 | Fill byte present this cycle |
| fill_addr_i | input | ADDR_W | Address of the fill byte |
| fill_data_i | input | 8 | Fill byte |
| lookup_req_i | input | 1 | Lookup strobe |
| lookup_addr_i | input | ADDR_W | Branch target address to look up |
| hit_o | output | 1 | Registered hit flag |
| data_o | output | 8 | Registered byte, 0 on miss |

## Verification
Lookup can coincide with two other operations: a fill of the very address being looked up, and a flush. The bench drives both strobes on the same falling edge. It expects a miss for the coinciding lookup, because the lookup is judged on the state before the write. When the bench repeats the lookup with no fill in the same cycle, it expects a hit with the filled byte. A flush that lands together with a lookup or a fill is judged the same way: the lookup misses, and the discarded fill must not count as the start of a window.

// File: rtl/lb_pkg.sv
package lb_pkg;
  localparam int unsigned LB_DATA_W = 8;
  typedef logic [LB_DATA_W-1:0] lb_byte_t;
  typedef struct packed {
    logic     hit;
    lb_byte_t data;
  } lb_resp_t;
endpackage

// File: rtl/lb_byte_store.sv
module lb_byte_store
  import lb_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  lb_byte_t         wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output lb_byte_t         rdata_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  lb_byte_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read returns pre-write contents on a same-slot collision
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/lb_window_ctrl.sv
module lb_window_ctrl #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              fill_valid_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic              lookup_req_i,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  output logic              wr_en_o,
  output logic              hit_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam int unsigned TAG_W = ADDR_W - IDX_W;

  logic [ADDR_W-1:0] last_addr_q;
  logic              have_last_q;
  logic [DEPTH-1:0]  valid_q;

  logic [IDX_W-1:0]  f_idx, l_idx, last_idx;
  logic [TAG_W-1:0]  l_tag, last_tag, slot_tag;
  logic              seq_fill;

  assign f_idx    = fill_addr_i[IDX_W-1:0];
  assign l_idx    = lookup_addr_i[IDX_W-1:0];
  assign l_tag    = lookup_addr_i[ADDR_W-1:IDX_W];
  assign last_idx = last_addr_q[IDX_W-1:0];
  assign last_tag = last_addr_q[ADDR_W-1:IDX_W];

  assign seq_fill = have_last_q && (fill_addr_i == last_addr_q + ADDR_W'(1));
  assign wr_en_o  = fill_valid_i && !flush_i;

  // slots above the newest index still hold bytes of the previous block
  assign slot_tag = (l_idx <= last_idx) ? last_tag : last_tag - TAG_W'(1);
  assign hit_o    = lookup_req_i && !flush_i && valid_q[l_idx] && (l_tag == slot_tag);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_addr_q <= '0;
      have_last_q <= 1'b0;
      valid_q     <= '0;
    end else if (flush_i) begin
      have_last_q <= 1'b0;
      valid_q     <= '0;
    end else if (fill_valid_i) begin
      last_addr_q <= fill_addr_i;
      have_last_q <= 1'b1;
      if (seq_fill) valid_q[f_idx] <= 1'b1;
      else          valid_q <= DEPTH'(1) << f_idx;
    end
  end

  a_r8_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0));

  a_r7_restart_one_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !flush_i && !seq_fill) |=> ($countones(valid_q) == 1));

  a_r6_seq_never_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !flush_i && seq_fill) |=> ($countones(valid_q) >= $past($countones(valid_q))));
endmodule

// File: rtl/loop_buffer.sv
module loop_buffer
  import lb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              fill_valid_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [7:0]        fill_data_i,
  input  logic              lookup_req_i,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  output logic              hit_o,
  output logic [7:0]        data_o
);
  logic     wr_en, hit_c;
  lb_byte_t rd_byte;
  lb_resp_t resp_q;

  lb_window_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .flush_i       (flush_i),
    .fill_valid_i  (fill_valid_i),
    .fill_addr_i   (fill_addr_i),
    .lookup_req_i  (lookup_req_i),
    .lookup_addr_i (lookup_addr_i),
    .wr_en_o       (wr_en),
    .hit_o         (hit_c)
  );

  lb_byte_store #(.IDX_W(IDX_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (wr_en),
    .waddr_i (fill_addr_i[IDX_W-1:0]),
    .wdata_i (fill_data_i),
    .raddr_i (lookup_addr_i[IDX_W-1:0]),
    .rdata_o (rd_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    resp_q <= '0;
    else if (hit_c) resp_q <= '{hit: 1'b1, data: rd_byte};
    else            resp_q <= '0;
  end

  assign hit_o  = resp_q.hit;
  assign data_o = resp_q.data;

  a_r2_no_req_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_req_i |=> !hit_o);

  a_r8_flush_blocks_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !hit_o);

  a_r4_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (data_o == 8'h00));
endmodule

// File: tb/sim_loop_buffer.sv
`timescale 1ns/1ps
module sim_loop_buffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        fvld = 1'b0;
  logic [31:0] faddr = '0;
  logic [7:0]  fdata = '0;
  logic        lreq = 1'b0;
  logic [31:0] laddr = '0;
  logic        hit;
  logic [7:0]  dout;
  int          n_chk = 0;
  int          n_err = 0;

  always #2.5 clk = ~clk;

  loop_buffer u0 (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .fill_valid_i(fvld), .fill_addr_i(faddr), .fill_data_i(fdata),
    .lookup_req_i(lreq), .lookup_addr_i(laddr),
    .hit_o(hit), .data_o(dout)
  );

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  task automatic check(input string req, input logic exp_h, input logic [7:0] exp_d);
    n_chk++;
    if (hit !== exp_h || dout !== exp_d) begin
      n_err++;
      $display("FAIL %s: got hit=%0b data=%02h, expected hit=%0b data=%02h",
               req, hit, dout, exp_h, exp_d);
    end
  endtask

  task automatic fill_run(input logic [31:0] a0, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fvld = 1'b1; faddr = a0 + 32'(i); fdata = pat(a0 + 32'(i));
    end
    @(negedge clk);
    fvld = 1'b0;
  endtask

  task automatic look(input logic [31:0] a, input logic exp_h, input string req);
    @(negedge clk);
    lreq = 1'b1; laddr = a;
    @(negedge clk);
    lreq = 1'b0;
    check(req, exp_h, exp_h ? pat(a) : 8'h00);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // {address, expected hit}; window after the run is 0x1110..0x120F
  localparam logic [32:0] LK_TBL [10] = '{
    {32'h0000_10F0, 1'b0},  // R6 overwritten oldest
    {32'h0000_110F, 1'b0},  // R6 one before window
    {32'h0000_1110, 1'b1},  // R6 oldest held
    {32'h0000_11FF, 1'b1},  // R6 below boundary
    {32'h0000_1200, 1'b1},  // R6 above boundary
    {32'h0000_120F, 1'b1},  // R3 newest
    {32'h0000_1150, 1'b1},  // R3 inside window
    {32'h0000_1210, 1'b0},  // R4 never filled
    {32'h0000_2150, 1'b0},  // R5 alias upper bits
    {32'h0000_0150, 1'b0}   // R5 alias upper bits
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout, expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", 1'b0, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 1'b0, 8'h00);
    look(32'h0000_10F0, 1'b0, "R1 empty lookup");

    fill_run(32'h0000_10F0, 288);
    for (int i = 0; i < 10; i++)
      look(LK_TBL[i][32:1], LK_TBL[i][0], "R3/R4/R5/R6 table");

    // R2: address of a held byte but no strobe
    @(negedge clk);
    laddr = 32'h0000_1150; lreq = 1'b0;
    @(negedge clk);
    check("R2 no request", 1'b0, 8'h00);
    look(32'h0000_1151, 1'b1, "R2 request answered next cycle");

    // R7: jump restarts the window
    fill_run(32'h0000_5000, 2);
    look(32'h0000_1150, 1'b0, "R7 old window dropped");
    look(32'h0000_120F, 1'b0, "R7 last old byte dropped");
    look(32'h0000_5000, 1'b1, "R7 new start");
    look(32'h0000_5001, 1'b1, "R7 sequential after restart");

    // R9: lookup coinciding with the fill of that address
    @(negedge clk);
    fvld = 1'b1; faddr = 32'h0000_5002; fdata = pat(32'h0000_5002);
    lreq = 1'b1; laddr = 32'h0000_5002;
    @(negedge clk);
    fvld = 1'b0; lreq = 1'b0;
    check("R9 same-cycle fill lookup", 1'b0, 8'h00);
    look(32'h0000_5002, 1'b1, "R9 hit one cycle later");

    // R8: flush alone
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    look(32'h0000_5000, 1'b0, "R8 flush clears");

    // R8: flush with lookup
    fill_run(32'h0000_6000, 4);
    @(negedge clk);
    flush = 1'b1; lreq = 1'b1; laddr = 32'h0000_6001;
    @(negedge clk);
    flush = 1'b0; lreq = 1'b0;
    check("R8 flush with lookup", 1'b0, 8'h00);

    // R8: flush with fill, next fill starts a window
    fill_run(32'h0000_6000, 4);
    @(negedge clk);
    flush = 1'b1; fvld = 1'b1; faddr = 32'h0000_6004; fdata = pat(32'h0000_6004);
    @(negedge clk);
    flush = 1'b0;
    faddr = 32'h0000_6005; fdata = pat(32'h0000_6005);
    @(negedge clk);
    fvld = 1'b0;
    look(32'h0000_6004, 1'b0, "R8 fill under flush discarded");
    look(32'h0000_6005, 1'b1, "R8 next fill starts window");
    look(32'h0000_6000, 1'b0, "R8 pre-flush byte gone");

    report();
    $finish;
  end
endmodule